// File: doc/BRIEF.md
# Message-Signalled Interrupt Receiver

This block turns message-signalled interrupt writes into level interrupts for a parent interrupt controller. A device signals an interrupt by writing a data word to one fixed target address. The low eight bits of that word name one of 256 vectors. The upper three of those bits pick one of eight 32-bit pending registers, and the lower five pick a bit inside it. The block sets that bit and keeps it set until software collects it.

Each pending register drives its own level interrupt line. The line is high while the register holds any pending bit and the register's mask bit is clear. Software reads a pending register through a single-cycle register port. The read returns the pending bits and clears them in the same access, so no acknowledge write is needed. Software then services the lowest set bit of the value it read. The block applies no priority inside a register.

Masking works per pending register, not per vector. A masked register still collects new messages, and its line rises as soon as the mask bit is cleared.

Top module: `msgirq_ctrl`

## Requirements
- R1: After reset all pending registers, the mask, `reg_rdata` and every `irq_o` line are zero.
- R2: A message is a cycle with `msg_valid` high, a matching address and `msg_data[31:8]` zero. It sets bit `msg_data[4:0]` of pending register `msg_data[7:5]`, and the bit is visible from the next cycle.
- R3: A message is dropped with no effect on any pending bit in three cases: `msg_addr_lo` is not 0xE00007F8, `msg_addr_hi` is not zero, or any of `msg_data[31:8]` is set.
- R4: A read (`reg_valid` high, `reg_write` low) at byte address 4*i, for i in 0..7, loads pending register i into `reg_rdata` on the next cycle and clears that register. `reg_rdata` holds its value while no read occurs.
- R5: A write at byte address 0x20 loads `reg_wdata[7:0]` into the mask. A read at 0x20 returns the mask in `reg_rdata[7:0]`, with zeros above, and has no side effect.
- R6: `irq_o[i]` is high exactly when pending register i is non-zero and mask bit i is zero. It follows register state from the cycle after that state changes.
- R7: A message to a masked register still sets its bit. The register's line rises in the cycle after the mask bit is cleared.
- R8: If a message and a clearing read target the same pending register in one cycle, the read returns the old contents and the new bit remains pending.
- R9: Repeated messages to a bit that is already pending leave a single pending bit, and one read clears it.
- R10: Writes to pending-register addresses change nothing. Reads at any address other than 0x00–0x20 on a word boundary return zero and clear nothing, and reads with `reg_addr[1:0]` non-zero count as such unmapped reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message write strobe |
| msg_addr_hi | input | 32 | Upper word of the message target address |
| msg_addr_lo | input | 32 | Lower word of the message target address |
| msg_data | input | 32 | Message data word carrying the vector |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data; only the mask is writable |
| reg_rdata | output | 32 | Read data, registered |
| irq_o | output | 8 | Level interrupt per pending register |

## Verification
A behavioural reference model runs beside the design on every clock and compares `reg_rdata` and `irq_o`. Directed messages to the first, last and a middle vector show that the register and bit fields are split correctly. Messages with a wrong address word or stray upper data bits show that the filter works. Same-cycle message/read pairs and repeated messages separate clear-before-set from set-before-clear and counting from collapsing. A scrambled stream mixes messages, reads, mask writes and unmapped accesses, to catch any interaction that the directed cases miss.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_STATUS   = 2'd1,
        ACC_MASK     = 2'd2,
        ACC_UNMAPPED = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/msgirq_decode.sv
module msgirq_decode #(
    parameter logic [31:0] TARGET_HI    = 32'h0000_0000,
    parameter logic [31:0] TARGET_LO    = 32'hE000_07F8,
    parameter int          DATA_W       = 32,
    parameter int          NUM_REGS     = 8,
    parameter int          BITS_PER_REG = 32,
    localparam int         BIT_W        = $clog2(BITS_PER_REG),
    localparam int         IDX_W        = $clog2(NUM_REGS),
    localparam int         VEC_W        = BIT_W + IDX_W
) (
    input  logic              valid_i,
    input  logic [31:0]       addr_hi_i,
    input  logic [31:0]       addr_lo_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  reg_idx_o,
    output logic [BIT_W-1:0]  bit_idx_o
);
    logic addr_ok;
    logic spare_clear;

    always_comb begin
        addr_ok     = (addr_hi_i == TARGET_HI) && (addr_lo_i == TARGET_LO);
        spare_clear = (data_i >> VEC_W) == '0;
        hit_o       = valid_i && addr_ok && spare_clear;
        reg_idx_o   = data_i[VEC_W-1:BIT_W];
        bit_idx_o   = data_i[BIT_W-1:0];
    end
endmodule

// File: rtl/msgirq_access.sv
module msgirq_access
    import msgirq_pkg::*;
#(
    parameter int  ADDR_W   = 8,
    parameter int  NUM_REGS = 8,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int WORD_W   = ADDR_W - 2
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              rd_en_o,
    output logic              wr_en_o
);
    logic [WORD_W-1:0] word;

    always_comb begin
        word    = addr_i[ADDR_W-1:2];
        idx_o   = word[IDX_W-1:0];
        rd_en_o = valid_i && !write_i;
        wr_en_o = valid_i && write_i;
        if (!valid_i)
            kind_o = ACC_NONE;
        else if (addr_i[1:0] != 2'b00)
            kind_o = ACC_UNMAPPED;
        else if (word < WORD_W'(NUM_REGS))
            kind_o = ACC_STATUS;
        else if (word == WORD_W'(NUM_REGS))
            kind_o = ACC_MASK;
        else
            kind_o = ACC_UNMAPPED;
    end
endmodule

// File: rtl/msgirq_bank.sv
module msgirq_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] status_o
);
    logic [WIDTH-1:0] status_d, status_q;

    always_comb begin
        status_d = status_q;
        if (clr_i)
            status_d = '0;
        status_d = status_d | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= status_d;
    end

    assign status_o = status_q;

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && set_i == '0) |=> $stable(status_q));

    p_read_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (status_q == '0));

    p_set_survives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i != '0) |=> (status_q == $past(set_i)));
endmodule

// File: rtl/msgirq_ctrl.sv
module msgirq_ctrl
    import msgirq_pkg::*;
#(
    parameter logic [31:0] TARGET_HI    = 32'h0000_0000,
    parameter logic [31:0] TARGET_LO    = 32'hE000_07F8,
    parameter int          DATA_W       = 32,
    parameter int          NUM_REGS     = 8,
    parameter int          BITS_PER_REG = 32,
    parameter int          ADDR_W       = 8,
    localparam int         BIT_W        = $clog2(BITS_PER_REG),
    localparam int         IDX_W        = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msg_valid,
    input  logic [31:0]             msg_addr_hi,
    input  logic [31:0]             msg_addr_lo,
    input  logic [DATA_W-1:0]       msg_data,
    input  logic                    reg_valid,
    input  logic                    reg_write,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [NUM_REGS-1:0]     reg_wdata,
    output logic [BITS_PER_REG-1:0] reg_rdata,
    output logic [NUM_REGS-1:0]     irq_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0]     mask;
        logic [BITS_PER_REG-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic             msg_hit;
    logic [IDX_W-1:0] msg_reg;
    logic [BIT_W-1:0] msg_bit;
    acc_kind_e        acc_kind;
    logic [IDX_W-1:0] acc_idx;
    logic             rd_en, wr_en;

    logic [NUM_REGS-1:0][BITS_PER_REG-1:0] status_bus;
    logic [NUM_REGS-1:0][BITS_PER_REG-1:0] set_vec;
    logic [NUM_REGS-1:0]                   clr_vec;

    msgirq_decode #(
        .TARGET_HI(TARGET_HI), .TARGET_LO(TARGET_LO), .DATA_W(DATA_W),
        .NUM_REGS(NUM_REGS), .BITS_PER_REG(BITS_PER_REG)
    ) u_decode (
        .valid_i(msg_valid), .addr_hi_i(msg_addr_hi), .addr_lo_i(msg_addr_lo),
        .data_i(msg_data), .hit_o(msg_hit), .reg_idx_o(msg_reg), .bit_idx_o(msg_bit)
    );

    msgirq_access #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
    ) u_access (
        .valid_i(reg_valid), .write_i(reg_write), .addr_i(reg_addr),
        .kind_o(acc_kind), .idx_o(acc_idx), .rd_en_o(rd_en), .wr_en_o(wr_en)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            set_vec[g] = (msg_hit && msg_reg == IDX_W'(g))
                       ? (BITS_PER_REG'(1) << msg_bit) : '0;
            clr_vec[g] = rd_en && acc_kind == ACC_STATUS && acc_idx == IDX_W'(g);
            irq_o[g]   = (|status_bus[g]) && !st_q.mask[g];
        end

        msgirq_bank #(.WIDTH(BITS_PER_REG)) u_bank (
            .clk(clk), .rst_n(rst_n), .set_i(set_vec[g]),
            .clr_i(clr_vec[g]), .status_o(status_bus[g])
        );

        p_read_quiets_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[g] && set_vec[g] == '0) |=> !irq_o[g]);
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            case (acc_kind)
                ACC_STATUS: st_d.rdata = status_bus[acc_idx];
                ACC_MASK: begin
                    st_d.rdata                = '0;
                    st_d.rdata[NUM_REGS-1:0]  = st_q.mask;
                end
                default:    st_d.rdata = '0;
            endcase
        end
        if (wr_en && acc_kind == ACC_MASK)
            st_d.mask = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == ADDR_W'(4 * NUM_REGS))
        |=> (st_q.mask == $past(reg_wdata)));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && reg_addr[1:0] != 2'b00) |=> (reg_rdata == '0));
endmodule

// File: tb/tb_msgirq_ctrl.sv
module tb_msgirq_ctrl;
    localparam logic [31:0] TGT = 32'hE000_07F8;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [31:0] msg_addr_hi = '0;
    logic [31:0] msg_addr_lo = '0;
    logic [31:0] msg_data = '0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [31:0] m_st [8];
    logic [7:0]  m_mask;
    logic [31:0] m_rd;

    always #10 clk = ~clk;

    msgirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_addr_hi(msg_addr_hi),
        .msg_addr_lo(msg_addr_lo), .msg_data(msg_data), .reg_valid(reg_valid),
        .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_irq();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = (m_st[i] != 0) && !m_mask[i];
        return v;
    endfunction

    // Drive at negedge, update the model at posedge, compare at the next negedge.
    task automatic step(input bit mv, input logic [31:0] ahi, input logic [31:0] alo,
                        input logic [31:0] dat, input bit rv, input bit rw,
                        input logic [7:0] ra, input logic [7:0] wd);
        msg_valid = mv; msg_addr_hi = ahi; msg_addr_lo = alo; msg_data = dat;
        reg_valid = rv; reg_write = rw; reg_addr = ra; reg_wdata = wd;
        @(posedge clk);
        if (rv && !rw) begin
            if (ra[1:0] == 2'b00 && ra[7:2] < 8) begin
                m_rd = m_st[ra[4:2]];
                m_st[ra[4:2]] = '0;
            end else if (ra == 8'h20) begin
                m_rd = {24'h0, m_mask};
            end else begin
                m_rd = '0;
            end
        end
        if (rv && rw && ra == 8'h20) m_mask = wd;
        if (mv && ahi == 0 && alo == TGT && dat[31:8] == 0)
            m_st[dat[7:5]][dat[4:0]] = 1'b1;
        @(negedge clk);
        check("R4 rdata model", reg_rdata, m_rd);
        check("R6 irq model", {24'h0, irq_o}, {24'h0, model_irq()});
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic msg(input logic [31:0] dat);
        step(1, 0, TGT, dat, 0, 0, 0, 0);
    endtask
    task automatic rd(input logic [7:0] a);
        step(0, 0, 0, 0, 1, 0, a, 0);
    endtask
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        step(0, 0, 0, 0, 1, 1, a, d);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < 8; i++) m_st[i] = '0;
        m_mask = '0; m_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 irq", {24'h0, irq_o}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd(8'(4 * i));
            check("R1 status zero", reg_rdata, 32'h0);
        end
        rd(8'h20);
        check("R1 mask zero", reg_rdata, 32'h0);

        // R2: vector field split, first/last/middle vectors
        msg(32'h0000_0000);
        msg(32'h0000_00FF);
        msg(32'h0000_0045);
        check("R2 irq lines", {24'h0, irq_o}, 32'h0000_0085);
        rd(8'h08);
        check("R2 reg2 bit5", reg_rdata, 32'h0000_0020);
        rd(8'h08);
        check("R4 reg2 cleared", reg_rdata, 32'h0);
        rd(8'h1C);
        check("R2 reg7 bit31", reg_rdata, 32'h8000_0000);
        rd(8'h00);
        check("R2 reg0 bit0", reg_rdata, 32'h0000_0001);
        idle();
        check("R4 rdata holds", reg_rdata, 32'h0000_0001);

        // R3: foreign address words and stray data bits
        step(1, 0, 32'hE000_07FC, 32'h0000_0011, 0, 0, 0, 0);
        step(1, 32'h1, TGT, 32'h0000_0011, 0, 0, 0, 0);
        step(1, 0, TGT, 32'h0000_0111, 0, 0, 0, 0);
        check("R3 no irq", {24'h0, irq_o}, 32'h0);
        rd(8'h00);
        check("R3 reg0 untouched", reg_rdata, 32'h0);

        // R5: mask write/readback without side effect
        wr(8'h20, 8'hA5);
        rd(8'h20);
        check("R5 mask readback", reg_rdata, 32'h0000_00A5);
        rd(8'h20);
        check("R5 mask read again", reg_rdata, 32'h0000_00A5);
        wr(8'h20, 8'h00);

        // R7: masked register keeps latching
        wr(8'h20, 8'h08);
        msg(32'h0000_0067);
        check("R7 masked line low", {24'h0, irq_o}, 32'h0);
        wr(8'h20, 8'h00);
        check("R7 line after unmask", {24'h0, irq_o}, 32'h0000_0008);
        rd(8'h0C);
        check("R7 latched bit", reg_rdata, 32'h0000_0080);
        check("R6 line drops after read", {24'h0, irq_o}, 32'h0);

        // R8: same-cycle message and read on one register
        msg(32'h0000_0081);
        step(1, 0, TGT, 32'h0000_0089, 1, 0, 8'h10, 0);
        check("R8 old value read", reg_rdata, 32'h0000_0002);
        check("R8 line stays", {24'h0, irq_o}, 32'h0000_0010);
        rd(8'h10);
        check("R8 new bit kept", reg_rdata, 32'h0000_0200);

        // R9: repeated message collapses
        msg(32'h0000_00B3);
        msg(32'h0000_00B3);
        msg(32'h0000_00B3);
        rd(8'h14);
        check("R9 single bit", reg_rdata, 32'h0008_0000);
        rd(8'h14);
        check("R9 cleared once", reg_rdata, 32'h0);

        // R10: status writes ignored, unmapped reads zero and side-effect free
        msg(32'h0000_0042);
        wr(8'h08, 8'hFF);
        rd(8'h30);
        check("R10 unmapped read zero", reg_rdata, 32'h0);
        rd(8'h09);
        check("R10 unaligned read zero", reg_rdata, 32'h0);
        check("R10 line intact", {24'h0, irq_o}, 32'h0000_0004);
        rd(8'h08);
        check("R10 status unchanged", reg_rdata, 32'h0000_0004);

        // Scrambled traffic against the model
        lf = 32'h1234_5678;
        for (int n = 0; n < 600; n++) begin
            bit mv, rv, rw, badaddr;
            logic [31:0] dat;
            logic [7:0] ra;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            mv = lf[20] | lf[21];
            badaddr = (lf[27:25] == 3'b000);
            dat = {(lf[30:28] == 3'b000) ? 24'h1 : 24'h0, lf[7:0]};
            rv = lf[22];
            rw = rv && (lf[24:23] == 2'b00);
            ra = rw ? 8'h20 : {2'b00, lf[13:10], (lf[31:29] == 3'b111) ? 2'b01 : 2'b00};
            step(mv, 0, badaddr ? 32'hE000_0000 : TGT, dat, rv, rw, ra, lf[19:12]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule